// File: doc/BRIEF.md
# Quantum Round-Robin Memory Port Arbiter

This block sits between several bus masters and one shared external memory port. Each master raises a request, presents an address, write data, a direction bit and a burst length, and waits for its grant. The arbiter hands the port to one master at a time, in rotating order. Once a master is granted, it keeps the grant for a minimum number of accepted transfers, its quantum. Longer stays on one master keep the memory's open-page switches rare.

A burst is atomic: once its first beat is accepted, the grant cannot move until the last beat is done. This holds even when the burst runs past the quantum, and even when the master pauses mid-burst. A master that stops requesting gives up the port at once. A master whose quantum is used up keeps the port for as long as nobody else is asking for it. The owner's request, address, data, direction and burst length are steered onto the memory side. A transfer beat counts only when the memory side is not stalling.

Top module: `qrr_mem_arb`

## Requirements
- R1: While reset is asserted and after it is released, `mst_grant` is all zeros and `mem_req` is low until a request arrives. The first grant after reset goes to the lowest-numbered requesting master.
- R2: `mst_grant` is registered and is either all zeros or one-hot. From idle, a request is granted at the first rising edge that samples it.
- R3: After master k is granted, the next owner is searched for starting at master k+1, wrapping from N-1 to 0. Master k itself is considered last.
- R4: While another master is requesting, the owner keeps the grant until it has completed its quantum of accepted beats. The grant moves at the same rising edge that accepts the final beat of the quantum.
- R5: If the owner drops its request while no burst is in progress, the grant moves at the next rising edge to the next requester in rotation. If no master is requesting, all grants go low.
- R6: When the owner's quantum is used up and no other master is requesting, the owner keeps the grant. It loses the grant at the first edge that sees another request.
- R7: `mst_len` holds the number of beats minus one. It is sampled only on a burst's first accepted beat. The grant stays with the owner until every remaining beat is accepted, even past the quantum and even while the owner's request is low.
- R8: A beat is accepted only when the owner requests and `mem_wait` is low. Stalled cycles consume neither quantum nor burst beats.
- R9: `mem_req` equals the owner's request. `mem_addr`, `mem_wdata`, `mem_wr` and `mem_len` carry the owner's fields. All of these are zero when no master is granted.
- R10: A master that keeps requesting is granted before the other masters together have had more than their quanta plus one maximal burst each.
- R11: The quantum is a parameter set separately for each master. The defaults are 2, 3, 4 and 2 beats for masters 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mst_req | input | N_MST | Per-master transfer request |
| mst_len | input | N_MST*LEN_W | Per-master burst beats minus one |
| mst_addr | input | N_MST*ADDR_W | Per-master address |
| mst_wdata | input | N_MST*DATA_W | Per-master write data |
| mst_wr | input | N_MST | Per-master write direction |
| mst_grant | output | N_MST | One-hot registered grant |
| mem_req | output | 1 | Request toward memory |
| mem_len | output | LEN_W | Burst length of the owner |
| mem_addr | output | ADDR_W | Owner address |
| mem_wdata | output | DATA_W | Owner write data |
| mem_wr | output | 1 | Owner write direction |
| mem_wait | input | 1 | Memory stall; no beat accepted while high |

## Verification
The bench targets the edges of a grant. It checks the exact cycle a quantum ends under contention: a design that releases one beat late or early shifts the whole grant sequence and fails there. A burst that runs past the quantum, with a pause in its middle, catches a design that splits bursts or re-reads the length mid-burst. Stalled cycles catch a design that charges the quantum for cycles with no accepted beat. Separate scenarios check idle hold, early release to none, and the resumed rotation after that release. Together they catch a design that bounces the grant needlessly, leaves a stale grant behind, or restarts its search from master 0.

// File: rtl/qrr_pkg.sv
package qrr_pkg;

  // Advance a master index by one, wrapping at the master count.
  function automatic int unsigned rr_wrap_inc(input int unsigned idx, input int unsigned count);
    return (idx + 1 >= count) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/qrr_rr_pick.sv
module qrr_rr_pick #(
  parameter int N_MST = 4,
  parameter int IDX_W = 2
) (
  input  logic [N_MST-1:0] req,
  input  logic [IDX_W-1:0] start,
  output logic             found,
  output logic [IDX_W-1:0] pick
);

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int off = 0; off < N_MST; off++) begin
      int cand;
      cand = int'(start) + off;
      if (cand >= N_MST) cand = cand - N_MST;
      if (!found && req[IDX_W'(cand)]) begin
        found = 1'b1;
        pick  = IDX_W'(cand);
      end
    end
  end

endmodule

// File: rtl/qrr_quota_ctr.sv
module qrr_quota_ctr #(
  parameter int SHARE_W = 8,
  parameter int LEN_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               beat,
  input  logic               load,
  input  logic [SHARE_W-1:0] load_val,
  input  logic [LEN_W-1:0]   first_len,
  output logic [SHARE_W-1:0] quota_ab,
  output logic [LEN_W-1:0]   brem_ab
);

  logic [SHARE_W-1:0] quota_q;
  logic [LEN_W-1:0]   brem_q;
  logic               ctr_en;

  // Values after this cycle's beat, before any reload.
  always_comb begin
    quota_ab = quota_q;
    brem_ab  = brem_q;
    if (beat) begin
      brem_ab  = (brem_q == '0) ? first_len : brem_q - 1'b1;
      quota_ab = (quota_q == '0) ? '0 : quota_q - 1'b1;
    end
    ctr_en = beat | load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quota_q <= '0;
      brem_q  <= '0;
    end else if (ctr_en) begin
      quota_q <= load ? load_val : quota_ab;
      brem_q  <= brem_ab;
    end
  end

  // A new owner is only loaded when no burst beat remains.
  assert_load_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (brem_ab == '0));

endmodule

// File: rtl/qrr_port_mux.sv
module qrr_port_mux #(
  parameter int N_MST  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 4
) (
  input  logic [N_MST-1:0]        grant,
  input  logic [N_MST-1:0]        req,
  input  logic [N_MST*LEN_W-1:0]  len,
  input  logic [N_MST*ADDR_W-1:0] addr,
  input  logic [N_MST*DATA_W-1:0] wdata,
  input  logic [N_MST-1:0]        wr,
  output logic                    mem_req,
  output logic [LEN_W-1:0]        mem_len,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [DATA_W-1:0]       mem_wdata,
  output logic                    mem_wr
);

  // AND-OR select over the one-hot grant.
  always_comb begin
    mem_req   = |(grant & req);
    mem_wr    = |(grant & wr);
    mem_len   = '0;
    mem_addr  = '0;
    mem_wdata = '0;
    for (int i = 0; i < N_MST; i++) begin
      mem_len   = mem_len   | (len[i*LEN_W +: LEN_W]     & {LEN_W{grant[i]}});
      mem_addr  = mem_addr  | (addr[i*ADDR_W +: ADDR_W]  & {ADDR_W{grant[i]}});
      mem_wdata = mem_wdata | (wdata[i*DATA_W +: DATA_W] & {DATA_W{grant[i]}});
    end
  end

endmodule

// File: rtl/qrr_mem_arb.sv
module qrr_mem_arb #(
  parameter int N_MST   = 4,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int LEN_W   = 4,
  parameter int SHARE_W = 8,
  parameter logic [N_MST*SHARE_W-1:0] SHARES = {8'd2, 8'd4, 8'd3, 8'd2}
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_MST-1:0]        mst_req,
  input  logic [N_MST*LEN_W-1:0]  mst_len,
  input  logic [N_MST*ADDR_W-1:0] mst_addr,
  input  logic [N_MST*DATA_W-1:0] mst_wdata,
  input  logic [N_MST-1:0]        mst_wr,
  output logic [N_MST-1:0]        mst_grant,
  output logic                    mem_req,
  output logic [LEN_W-1:0]        mem_len,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [DATA_W-1:0]       mem_wdata,
  output logic                    mem_wr,
  input  logic                    mem_wait
);

  import qrr_pkg::*;

  localparam int IDX_W      = (N_MST > 1) ? $clog2(N_MST) : 1;
  localparam int STARVE_MAX = (N_MST - 1) * ((1 << SHARE_W) + (1 << LEN_W));

  logic               own_vld, own_vld_n;
  logic [IDX_W-1:0]   own_idx, own_idx_n;
  logic [IDX_W-1:0]   ptr_q, ptr_n;
  logic [N_MST-1:0]   grant_q, grant_n;
  logic               own_req, beat, others, keep, load, arb_en;
  logic               pick_vld;
  logic [IDX_W-1:0]   pick_idx;
  logic [SHARE_W-1:0] quota_ab, load_val;
  logic [LEN_W-1:0]   brem_ab;

  assign own_req  = own_vld & mst_req[own_idx];
  assign beat     = own_req & ~mem_wait;
  assign others   = |(mst_req & ~grant_q);
  assign load_val = SHARES[pick_idx*SHARE_W +: SHARE_W];

  qrr_rr_pick #(.N_MST(N_MST), .IDX_W(IDX_W)) pick_i (
    .req   (mst_req),
    .start (ptr_q),
    .found (pick_vld),
    .pick  (pick_idx)
  );

  qrr_quota_ctr #(.SHARE_W(SHARE_W), .LEN_W(LEN_W)) ctr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat      (beat),
    .load      (load),
    .load_val  (load_val),
    .first_len (mst_len[own_idx*LEN_W +: LEN_W]),
    .quota_ab  (quota_ab),
    .brem_ab   (brem_ab)
  );

  // Next-owner decision using the post-beat counter values.
  always_comb begin
    keep      = own_vld & ((brem_ab != '0) | (own_req & ((quota_ab != '0) | ~others)));
    load      = ~keep & pick_vld;
    arb_en    = ~keep;
    own_vld_n = own_vld;
    own_idx_n = own_idx;
    ptr_n     = ptr_q;
    if (!keep) begin
      own_vld_n = pick_vld;
      if (pick_vld) begin
        own_idx_n = pick_idx;
        ptr_n     = IDX_W'(rr_wrap_inc(int'(pick_idx), N_MST));
      end
    end
    grant_n = '0;
    if (own_vld_n) grant_n[own_idx_n] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_vld <= 1'b0;
      own_idx <= '0;
      ptr_q   <= '0;
      grant_q <= '0;
    end else if (arb_en) begin
      own_vld <= own_vld_n;
      own_idx <= own_idx_n;
      ptr_q   <= ptr_n;
      grant_q <= grant_n;
    end
  end

  assign mst_grant = grant_q;

  qrr_port_mux #(.N_MST(N_MST), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) mux_i (
    .grant     (grant_q),
    .req       (mst_req),
    .len       (mst_len),
    .addr      (mst_addr),
    .wdata     (mst_wdata),
    .wr        (mst_wr),
    .mem_req   (mem_req),
    .mem_len   (mem_len),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_wr    (mem_wr)
  );

  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mst_grant));

  assert_burst_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (own_vld && brem_ab != '0) |=> $stable(mst_grant));

  assert_quantum_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (own_req && quota_ab != '0) |=> $stable(mst_grant));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (own_req && !others) |=> $stable(mst_grant));

  assert_no_owner_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_grant == '0) |-> !mem_req);

  // Beats given to others while a master keeps waiting stay bounded.
  for (genvar g = 0; g < N_MST; g++) begin : g_starve
    logic [31:0] wait_beats;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wait_beats <= '0;
      else if (!(mst_req[g] && !grant_q[g])) wait_beats <= '0;
      else if (beat) wait_beats <= wait_beats + 1;
    end
    assert_wait_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wait_beats <= 32'(STARVE_MAX));
  end

endmodule

// File: tb/qrr_mem_arb_tb.sv
module qrr_mem_arb_tb_top;

  localparam int N = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  mst_req;
  logic [N*4-1:0]  mst_len;
  logic [N*16-1:0] mst_addr;
  logic [N*32-1:0] mst_wdata;
  logic [N-1:0]  mst_wr;
  logic [N-1:0]  mst_grant;
  logic          mem_req;
  logic [3:0]    mem_len;
  logic [15:0]   mem_addr;
  logic [31:0]   mem_wdata;
  logic          mem_wr;
  logic          mem_wait;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  qrr_mem_arb dut_i (
    .clk(clk), .rst_n(rst_n), .mst_req(mst_req), .mst_len(mst_len),
    .mst_addr(mst_addr), .mst_wdata(mst_wdata), .mst_wr(mst_wr),
    .mst_grant(mst_grant), .mem_req(mem_req), .mem_len(mem_len),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wr(mem_wr),
    .mem_wait(mem_wait)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic gnt_is(input string rq, input logic [N-1:0] exp);
    chk(mst_grant == exp, rq, "grant", mst_grant, exp);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n     = 1'b0;
    mst_req   = '0;
    mst_len   = '0;
    mem_wait  = 1'b0;
    mst_wr    = 4'b0101;
    for (int i = 0; i < N; i++) begin
      mst_addr[i*16 +: 16]  = 16'h1000 * (i + 1) + 16'h34;
      mst_wdata[i*32 +: 32] = 32'hA000_0000 + i;
    end
    repeat (3) @(posedge clk);
    step();
    rst_n = 1'b1;
  endtask

  // R1: reset state with requests pending.
  task automatic t_reset();
    rst_n = 1'b0;
    mst_req = 4'b1111;
    repeat (2) step();
    gnt_is("R1", 4'b0000);
    chk(mem_req == 1'b0, "R1", "mem_req in reset", mem_req, 0);
    do_reset();
    step();
    gnt_is("R1", 4'b0000);
    chk(mem_req == 1'b0, "R1", "mem_req idle", mem_req, 0);
  endtask

  // R2 R4 R11: two masters alternate by quantum (m0 2 beats, m1 3 beats).
  task automatic t_quantum();
    do_reset();
    mst_req = 4'b0011;
    step(); gnt_is("R2", 4'b0001);
    step(); gnt_is("R4", 4'b0001);
    for (int k = 0; k < 3; k++) begin step(); gnt_is("R11", 4'b0010); end
    step(); gnt_is("R4", 4'b0001);
    step(); gnt_is("R4", 4'b0001);
    step(); gnt_is("R4", 4'b0010);
  endtask

  // R8: stalled cycles do not consume the quantum.
  task automatic t_stall();
    do_reset();
    mst_req  = 4'b0101;
    mem_wait = 1'b1;
    for (int k = 0; k < 3; k++) begin step(); gnt_is("R8", 4'b0001); end
    mem_wait = 1'b0;
    step(); gnt_is("R8", 4'b0001);
    step(); gnt_is("R8", 4'b0100);
  endtask

  // R6: sole requester holds past its quantum, yields when another asks.
  task automatic t_hold();
    do_reset();
    mst_req = 4'b1000;
    for (int k = 0; k < 10; k++) begin step(); gnt_is("R6", 4'b1000); end
    mst_req = 4'b1010;
    step(); gnt_is("R6", 4'b0010);
  endtask

  // R5 R3: early release, release to none, rotation resumes from pointer.
  task automatic t_release();
    do_reset();
    mst_req = 4'b0110;
    step(); gnt_is("R5", 4'b0010);
    mst_req = 4'b0100;
    step(); gnt_is("R5", 4'b0100);
    mst_req = 4'b0000;
    step(); gnt_is("R5", 4'b0000);
    chk(mem_req == 1'b0, "R5", "mem_req after release", mem_req, 0);
    mst_req = 4'b1001;
    step(); gnt_is("R3", 4'b1000);
  endtask

  // R7 R9: 5-beat burst over a 2-beat quantum with a pause in the middle.
  task automatic t_burst();
    do_reset();
    mst_len[3:0] = 4'd4;
    mst_req = 4'b0011;
    step(); gnt_is("R7", 4'b0001);
    chk(mem_req == 1'b1, "R9", "mem_req", mem_req, 1);
    chk(mem_addr == 16'h1034, "R9", "mem_addr", mem_addr, 16'h1034);
    chk(mem_wdata == 32'hA000_0000, "R9", "mem_wdata", mem_wdata, 32'hA000_0000);
    chk(mem_len == 4'd4, "R9", "mem_len", mem_len, 4);
    chk(mem_wr == 1'b1, "R9", "mem_wr", mem_wr, 1);
    step(); gnt_is("R7", 4'b0001);
    mst_len[3:0] = 4'd0;
    step(); gnt_is("R7", 4'b0001);
    mst_req = 4'b0010;
    step(); gnt_is("R7", 4'b0001);
    chk(mem_req == 1'b0, "R9", "mem_req paused", mem_req, 0);
    step(); gnt_is("R7", 4'b0001);
    mst_req = 4'b0011;
    step(); gnt_is("R7", 4'b0001);
    step(); gnt_is("R7", 4'b0001);
    step(); gnt_is("R7", 4'b0010);
    chk(mem_addr == 16'h2034, "R9", "mem_addr m1", mem_addr, 16'h2034);
    chk(mem_wr == 1'b0, "R9", "mem_wr m1", mem_wr, 0);
  endtask

  // R3 R10 R11: all masters request; full rotation then bounded waiting.
  task automatic t_rotate();
    int gap [N];
    int maxgap [N];
    int seen [N];
    int shares [N] = '{2, 3, 4, 2};
    do_reset();
    mst_req = 4'b1111;
    for (int m = 0; m < N; m++) begin
      for (int k = 0; k < shares[m]; k++) begin
        step(); gnt_is("R3", 4'(1 << m));
      end
    end
    step(); gnt_is("R3", 4'b0001);
    for (int m = 0; m < N; m++) begin gap[m] = 0; maxgap[m] = 0; seen[m] = 0; end
    for (int c = 0; c < 60; c++) begin
      step();
      for (int m = 0; m < N; m++) begin
        if (mst_grant[m]) begin seen[m]++; gap[m] = 0; end
        else begin gap[m]++; if (gap[m] > maxgap[m]) maxgap[m] = gap[m]; end
      end
    end
    for (int m = 0; m < N; m++) begin
      chk(seen[m] > 0, "R10", "master served", seen[m], 1);
      chk(maxgap[m] <= 11 - shares[m], "R10", "longest wait", maxgap[m], 11 - shares[m]);
    end
  endtask

  initial begin
    t_reset();
    t_quantum();
    t_stall();
    t_hold();
    t_release();
    t_burst();
    t_rotate();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule